// File: doc/BRIEF.md
# Stereo-to-dual-mono serial audio reformatter

The block takes one stereo serial audio stream and turns it into two mono serial lines, each meant for its own mono converter. The input comes as a bit clock, a word clock and a serial data bit. It uses I2S alignment: each channel has a 32-slot half-frame, and the sample's MSB arrives one bit clock after the word clock changes. Word clock low marks the left half-frame and high marks the right half-frame. A frame is one low half followed by one high half.

Each output line carries the word of one channel only. The word is right-justified within the phase where that line's own word clock is high, so its LSB is the last bit before that word clock falls. A seven-bit delay line moves the I2S-aligned word into the right-justified position. In simultaneous mode, a one-slot buffer holds the left word back by 32 bit clocks, so both lines present their words in the high phase of the same frame and both converters latch together. In alternating mode the buffer is skipped. The left line then gets an inverted word clock, so the two converters update on alternate half-frames.

Top module: `stereo_mono_split`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every output is low after that edge, whatever the inputs are.
- R2: After each rising edge taken out of reset, `ws_right` equals the `ws_in` value sampled at that same edge.
- R3: `ws_left` equals `ws_right` in simultaneous mode (`alt_mode` = 0) and is its inverse in alternating mode (`alt_mode` = 1).
- R4: Both data lines stay low from reset until the first falling `ws_in` edge that follows a rising one, so the first frame after reset gives all-zero lines.
- R5: Input slot positions count from 0 at the first sample after a `ws_in` change, and the input MSB sits at position 1. In the high phase, the right line carries the right word of the same frame at output positions SLOT_LEN-DATA_W to SLOT_LEN-1, MSB first. The delay is SLOT_LEN-DATA_W-1 bit clocks.
- R6: In simultaneous mode, the left line carries the left word of the same frame in those same high-phase positions, which is 32 bit clocks after the word arrived.
- R7: In alternating mode, the left line carries the left word in positions SLOT_LEN-DATA_W to SLOT_LEN-1 of the low phase of the same frame. This is the phase in which `ws_left` is high.
- R8: At every other position, each data line is low, whatever bits the input carries in its padding positions.
- R9: The mode is taken from `alt_mode` only while `rst` is high. A change of `alt_mode` outside reset does not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling and shifting on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alt_mode | input | 1 | 0 = simultaneous (buffered), 1 = alternating (inverted left word clock); captured during reset |
| ws_in | input | 1 | Input word clock, low = left half-frame |
| sd_in | input | 1 | Input serial data, I2S-aligned |
| sd_left | output | 1 | Right-justified left-channel mono line |
| sd_right | output | 1 | Right-justified right-channel mono line |
| ws_left | output | 1 | Word clock for the left converter |
| ws_right | output | 1 | Word clock for the right converter |

## Verification
Every output register is loaded at the edge that samples the corresponding input position. The word clocks are therefore due right after the edge that took `ws_in`. A data bit is due right after the edge at the position where it belongs: 7 edges after its input sample on the direct path, and 39 on the buffered left path. The bench drives each input position one time unit after a rising edge and reads the outputs one time unit after the next edge. This gives exactly one output position per input position, so the expected 64-position frame vectors are built per position index, with no search for alignment.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic {
    MODE_SIMUL = 1'b0,
    MODE_ALT   = 1'b1
  } split_mode_e;

  // bit clocks that move an I2S-placed word to the right-justified place
  function automatic int unsigned align_shift(int unsigned slot_len, int unsigned data_w);
    return slot_len - data_w - 1;
  endfunction

  // true for slot positions that hold a right-justified word bit
  function automatic logic word_window(int unsigned pos, int unsigned slot_len,
                                       int unsigned data_w);
    return (pos >= slot_len - data_w) && (pos <= slot_len - 1);
  endfunction

endpackage

// File: rtl/sms_slot_tracker.sv
module sms_slot_tracker #(
  parameter int SLOT_LEN = 32,
  parameter int POS_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws,
  output logic [POS_W-1:0] pos_now,
  output logic             ready
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_LEN - 1);

  logic             ws_q;
  logic [POS_W-1:0] pos_q;
  logic             seen_rise_q;
  logic             ready_q;

  logic ws_flip, ws_rise, ws_fall;
  assign ws_flip = ws ^ ws_q;
  assign ws_rise = ws & ~ws_q;
  assign ws_fall = ~ws & ws_q;

  always_comb begin
    if (ws_flip)
      pos_now = '0;
    else if (pos_q == LAST_POS)
      pos_now = pos_q;
    else
      pos_now = pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q        <= 1'b0;
      pos_q       <= LAST_POS;
      seen_rise_q <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      ws_q  <= ws;
      pos_q <= pos_now;
      if (ws_rise)
        seen_rise_q <= 1'b1;
      if (ws_fall && seen_rise_q)
        ready_q <= 1'b1;
    end
  end

  assign ready = ready_q;

endmodule

// File: rtl/sms_bit_delay.sv
module sms_bit_delay #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else if (DEPTH == 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [DEPTH-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= {q[DEPTH-2:0], din};
      end
      assign dout = q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/sms_lane.sv
module sms_lane (
  input  logic clk,
  input  logic rst,
  input  logic open,
  input  logic bit_in,
  input  logic ws_src,
  input  logic ws_inv,
  output logic sd,
  output logic ws
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sd <= 1'b0;
      ws <= 1'b0;
    end else begin
      sd <= open & bit_in;
      ws <= ws_src ^ ws_inv;
    end
  end

endmodule

// File: rtl/stereo_mono_split.sv
module stereo_mono_split #(
  parameter int DATA_W   = 24,
  parameter int SLOT_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic alt_mode,
  input  logic ws_in,
  input  logic sd_in,
  output logic sd_left,
  output logic sd_right,
  output logic ws_left,
  output logic ws_right
);
  import sms_pkg::*;

  localparam int SHIFT = int'(align_shift(SLOT_LEN, DATA_W));
  localparam int POS_W = $clog2(SLOT_LEN);
  localparam int LANES = 2;   // lane 0 = left, lane 1 = right

  split_mode_e      mode_q;
  logic             alt_q;
  logic [POS_W-1:0] pos_now;
  logic             ready;
  logic             in_word;
  logic             tap_rj;
  logic             tap_buf;
  logic             left_open;
  logic             right_open;

  // mode is only taken while reset is held
  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= alt_mode ? MODE_ALT : MODE_SIMUL;
  end
  assign alt_q = (mode_q == MODE_ALT);

  sms_slot_tracker #(.SLOT_LEN(SLOT_LEN), .POS_W(POS_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .ws      (ws_in),
    .pos_now (pos_now),
    .ready   (ready)
  );

  sms_bit_delay #(.DEPTH(SHIFT)) u_align (
    .clk  (clk),
    .rst  (rst),
    .din  (sd_in),
    .dout (tap_rj)
  );

  sms_bit_delay #(.DEPTH(SLOT_LEN)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .din  (tap_rj),
    .dout (tap_buf)
  );

  assign in_word    = word_window(int'(pos_now), SLOT_LEN, DATA_W);
  assign right_open = ready & in_word & ws_in;
  assign left_open  = ready & in_word & (alt_q ? ~ws_in : ws_in);

  logic [LANES-1:0] lane_open, lane_bit, lane_inv, lane_sd, lane_ws;
  assign lane_open = {right_open, left_open};
  assign lane_bit  = {tap_rj, (alt_q ? tap_rj : tap_buf)};
  assign lane_inv  = {1'b0, alt_q};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      sms_lane u_lane (
        .clk    (clk),
        .rst    (rst),
        .open   (lane_open[g]),
        .bit_in (lane_bit[g]),
        .ws_src (ws_in),
        .ws_inv (lane_inv[g]),
        .sd     (lane_sd[g]),
        .ws     (lane_ws[g])
      );
    end
  endgenerate

  assign sd_left  = lane_sd[0];
  assign sd_right = lane_sd[1];
  assign ws_left  = lane_ws[0];
  assign ws_right = lane_ws[1];

endmodule

// File: rtl/sms_checker.sv
module sms_checker (
  input logic clk,
  input logic rst,
  input logic ws_in,
  input logic alt_q,
  input logic right_open,
  input logic left_open,
  input logic tap_rj,
  input logic tap_buf,
  input logic sd_left,
  input logic sd_right,
  input logic ws_left,
  input logic ws_right
);
  logic seen_q = 1'b0;
  logic live_q = 1'b0;   // previous edge was a non-reset edge after a reset

  always_ff @(posedge clk) begin
    seen_q <= seen_q | rst;
    live_q <= (seen_q | rst) & ~rst;
  end

  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!sd_left && !sd_right && !ws_left && !ws_right));

  a_r2_ws_follow: assert property (@(posedge clk) disable iff (rst || !live_q)
    ws_right == $past(ws_in));

  a_r3_ws_pair: assert property (@(posedge clk) disable iff (rst || !live_q)
    ws_left == (ws_right ^ alt_q));

  a_r5_right_bit: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(right_open) |-> sd_right == $past(tap_rj));

  a_r6_left_buffered: assert property (@(posedge clk) disable iff (rst || !live_q)
    ($past(left_open) && !alt_q) |-> sd_left == $past(tap_buf));

  a_r7_left_direct: assert property (@(posedge clk) disable iff (rst || !live_q)
    ($past(left_open) && alt_q) |-> sd_left == $past(tap_rj));

  a_r8_right_quiet: assert property (@(posedge clk) disable iff (rst || !live_q)
    !$past(right_open) |-> !sd_right);

  a_r8_left_quiet: assert property (@(posedge clk) disable iff (rst || !live_q)
    !$past(left_open) |-> !sd_left);

endmodule

bind stereo_mono_split sms_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .ws_in      (ws_in),
  .alt_q      (alt_q),
  .right_open (right_open),
  .left_open  (left_open),
  .tap_rj     (tap_rj),
  .tap_buf    (tap_buf),
  .sd_left    (sd_left),
  .sd_right   (sd_right),
  .ws_left    (ws_left),
  .ws_right   (ws_right)
);

// File: tb/stereo_mono_split_test.sv
module stereo_mono_split_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 24;
  localparam int SLOT = 32;
  localparam int FR   = 2 * SLOT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alt_mode = 1'b0;
  logic ws_in = 1'b0;
  logic sd_in = 1'b0;
  logic sd_left, sd_right, ws_left, ws_right;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  stereo_mono_split #(.DATA_W(DW), .SLOT_LEN(SLOT)) uut (
    .clk      (clk),
    .rst      (rst),
    .alt_mode (alt_mode),
    .ws_in    (ws_in),
    .sd_in    (sd_in),
    .sd_left  (sd_left),
    .sd_right (sd_right),
    .ws_left  (ws_left),
    .ws_right (ws_right)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [FR-1:0] got, input logic [FR-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // expected line: word right-justified in the chosen half (0 = low phase, 1 = high phase)
  function automatic logic [FR-1:0] lane_expect(logic [DW-1:0] w, bit half_sel, bit on);
    logic [FR-1:0] v = '0;
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < SLOT; p++)
        if (on && (h == int'(half_sel)) && (p >= SLOT - DW))
          v[h*SLOT + p] = w[SLOT-1-p];
    return v;
  endfunction

  function automatic logic [FR-1:0] ws_expect(bit inv);
    logic [FR-1:0] v;
    for (int i = 0; i < FR; i++) v[i] = ((i >= SLOT) ? 1'b1 : 1'b0) ^ inv;
    return v;
  endfunction

  task automatic step(input logic w, input logic s);
    ws_in = w;
    sd_in = s;
    @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input logic [DW-1:0] lw, input logic [DW-1:0] rw,
                           input bit on, input bit alt, input string tag);
    logic [FR-1:0] g_l, g_r, g_wl, g_wr;
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < SLOT; p++) begin
        logic [DW-1:0] w = (h == 0) ? lw : rw;
        logic s = (p >= 1 && p <= DW) ? w[DW-p] : 1'($urandom % 2);
        step(1'(h), s);
        g_l [h*SLOT + p] = sd_left;
        g_r [h*SLOT + p] = sd_right;
        g_wl[h*SLOT + p] = ws_left;
        g_wr[h*SLOT + p] = ws_right;
      end
    chk({tag, " R5 R8 right line"}, g_r, lane_expect(rw, 1'b1, on));
    if (alt)
      chk({tag, " R7 R8 left line"}, g_l, lane_expect(lw, 1'b0, on));
    else
      chk({tag, " R6 R8 left line"}, g_l, lane_expect(lw, 1'b1, on));
    chk({tag, " R2 ws_right"}, g_wr, ws_expect(1'b0));
    chk({tag, " R3 ws_left"}, g_wl, ws_expect(alt));
  endtask

  task automatic do_reset(input bit m);
    rst = 1'b1;
    alt_mode = m;
    ws_in = 1'b1;
    sd_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outputs in reset", {60'd0, sd_left, sd_right, ws_left, ws_right}, '0);
    rst = 1'b0;
    ws_in = 1'b0;
  endtask

  task automatic run_mode(input bit m);
    do_reset(m);
    // first frame after reset: lines still held low
    run_frame(24'hA5A5A5, 24'h5A5A5A, 1'b0, m, "R4 first frame");
    // R9: flip the mode pin outside reset, behaviour must not change
    alt_mode = ~m;
    run_frame(24'hFFFFFF, 24'hFFFFFF, 1'b1, m, "R9 all ones");
    run_frame(24'h800001, 24'h000000, 1'b1, m, "R9 edge bits");
    run_frame(24'h000000, 24'h800001, 1'b1, m, "R9 swapped edge bits");
    for (int k = 0; k < 6; k++)
      run_frame(24'($urandom), 24'($urandom), 1'b1, m, "R9 random");
  endtask

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 2 + 1);
    run_mode(1'b0);
    run_mode(1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule